// File: doc/BRIEF.md
# Root Clock Generator with Fractional Counter

This block builds one output clock from one of two sources: a slow crystal reference and a fast PLL. Both sources reach the block as one-cycle strobes in its core clock domain, each strobe standing for one source edge. The selected strobe stream goes first through a pre-divider that can divide in half steps. It then goes either to a toggle stage or to an M/N:D phase counter, which sets both the frequency ratio and the duty cycle. The result is the registered level `clk_out`.

Software stages the settings through a small word-addressed register port. The addresses are 0 for command, 1 for configuration, 2 for M, 3 for N-code and 4 for D-code. A write of 1 to bit 0 of the command word raises an update request. The hardware copies all staged values into the active set at the first clock edge on which the output is low, and then clears the request. Software polls the bit until it reads 0. The register port has no stream interface and uses plain strobes: each write is accepted in the cycle it is presented, and reads are combinational.

Top module: `rcg_root`

## Requirements
- R1: After reset `clk_out` is 0 and every register reads 0. This means the reference source is selected, the pre-divider and counter are bypassed, and the update bit is clear.
- R2: The configuration word keeps only bits 13:0. Bits 31:14 read as 0 whatever was written.
- R3: Configuration bits 10:8 choose the source. Value 1 selects the PLL strobe, and every other value selects the reference strobe.
- R4: Configuration bits 4:0 hold the pre-divider code c. When c is 0 every source strobe passes through. Otherwise, any run of c+1 source strobes yields exactly two divided pulses, so each code step changes the ratio by one half (ratio (c+1)/2).
- R5: Counter mode is on when configuration bits 13:12 equal 2 and the N-code is non-zero. N is decoded as (NOT N-code) + M, and 2D is decoded as NOT D-code, both at register width. The phase starts at 0, and each divided pulse adds M to it modulo N. After each pulse `clk_out` is high exactly when 2*phase < 2D. With M and N coprime, any N consecutive pulses therefore give D high cycles.
- R6: Outside counter mode, whether the mode field is not 2 or the N-code is 0, `clk_out` inverts on every divided pulse.
- R7: Writing 1 to command bit 0 sets a pending flag, and the flag reads back on bit 0. The staged settings become active, the divider and phase state restart from 0, and the flag clears, all on the first edge on which `clk_out` is low. `clk_out` does not change on that edge.
- R8: While the flag is pending, writes to the configuration, M, N-code and D-code registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | Reference source edge strobe |
| pll_en | input | 1 | PLL source edge strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address (0 cmd, 1 cfg, 2 M, 3 N-code, 4 D-code) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| clk_out | output | 1 | Generated clock level |

## Verification
A register write takes effect at the clock edge that samples it, and read data is valid in the same cycle. The update flag therefore reads 1 straight after the command edge and clears on the first later edge that finds `clk_out` low. `clk_out` is a register, so it reflects a divided pulse one edge after the strobe that caused it. The bench samples only at falling edges and waits until the update flag reads 0. It then lets 40 settling cycles pass and counts toggles or high levels over a window whose length is a whole number of divider or counter periods. This makes each expected count exact and independent of where the window starts.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam logic [2:0] ADR_CMD = 3'd0;
  localparam logic [2:0] ADR_CFG = 3'd1;
  localparam logic [2:0] ADR_M   = 3'd2;
  localparam logic [2:0] ADR_N   = 3'd3;
  localparam logic [2:0] ADR_D   = 3'd4;

  localparam int CFGW = 14;
  localparam int DIVW = 5;
  localparam logic [1:0] MODE_COUNTER = 2'd2;
  localparam logic [2:0] SRC_PLL      = 3'd1;

  typedef struct packed {
    logic [1:0]      mode;
    logic            spare11;
    logic [2:0]      src;
    logic [2:0]      spare7;
    logic [DIVW-1:0] div;
  } cfg_t;
endpackage

// File: rtl/rcg_regs.sv
module rcg_regs
  import rcg_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          out_level,
  output logic          apply,
  output cfg_t          act_cfg,
  output logic [MW-1:0] act_m,
  output logic [MW-1:0] act_n,
  output logic [MW-1:0] act_d
);
  cfg_t          stg_cfg;
  logic [MW-1:0] stg_m, stg_n, stg_d;
  logic          pend;
  logic          open_wr;

  assign open_wr = wr && !pend;
  assign apply   = pend && !out_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_cfg <= '0;
      stg_m   <= '0;
      stg_n   <= '0;
      stg_d   <= '0;
    end else if (open_wr) begin
      case (addr)
        ADR_CFG: stg_cfg <= cfg_t'(wdata[CFGW-1:0]);
        ADR_M:   stg_m   <= wdata[MW-1:0];
        ADR_N:   stg_n   <= wdata[MW-1:0];
        ADR_D:   stg_d   <= wdata[MW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (apply) begin
      pend <= 1'b0;
    end else if (wr && addr == ADR_CMD && wdata[0]) begin
      pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cfg <= '0;
      act_m   <= '0;
      act_n   <= '0;
      act_d   <= '0;
    end else if (apply) begin
      act_cfg <= stg_cfg;
      act_m   <= stg_m;
      act_n   <= stg_n;
      act_d   <= stg_d;
    end
  end

  always_comb begin
    case (addr)
      ADR_CMD: rdata = {31'b0, pend};
      ADR_CFG: rdata = 32'(stg_cfg);
      ADR_M:   rdata = 32'(stg_m);
      ADR_N:   rdata = 32'(stg_n);
      ADR_D:   rdata = 32'(stg_d);
      default: rdata = '0;
    endcase
  end

  // R7: the request only retires while the output sits low
  a_r7_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> !$past(out_level));

  // R8: staged values are frozen while a request is pending
  a_r8_stage_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && wr && addr != ADR_CMD) |=> $stable({stg_cfg, stg_m, stg_n, stg_d}));
endmodule

// File: rtl/rcg_halfdiv.sv
module rcg_halfdiv #(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          load,
  input  logic [DW-1:0] code,
  output logic          pulse
);
  localparam int AW = DW + 1;

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;
  logic [AW-1:0] limit;
  logic          bypass;
  logic          hit;

  assign bypass = (code == '0);
  assign limit  = AW'(code) + AW'(1);
  assign sum    = acc + AW'(2);
  assign hit    = strobe && (sum >= limit);
  assign pulse  = bypass ? strobe : hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (load) begin
      acc <= '0;
    end else if (strobe && !bypass) begin
      acc <= hit ? (sum - limit) : sum;
    end
  end

  // R4: the half-step accumulator never reaches the divide limit
  a_r4_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> acc < limit);
endmodule

// File: rtl/rcg_mnd.sv
module rcg_mnd #(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse,
  input  logic          load,
  input  logic          cnt_mode,
  input  logic [MW-1:0] m_val,
  input  logic [MW-1:0] n_code,
  input  logic [MW-1:0] d_code,
  output logic          out_q
);
  localparam int XW = MW + 1;

  logic [MW-1:0] n_dec;
  logic [MW-1:0] d2_dec;
  logic [MW-1:0] phase;
  logic [XW-1:0] step;
  logic [MW-1:0] phase_nx;
  logic          high_nx;

  assign n_dec  = (~n_code) + m_val;
  assign d2_dec = ~d_code;
  assign step   = XW'(phase) + XW'(m_val);

  always_comb begin
    if (step >= XW'(n_dec)) phase_nx = MW'(step - XW'(n_dec));
    else                    phase_nx = MW'(step);
  end

  assign high_nx = ({phase_nx, 1'b0} < {1'b0, d2_dec});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      out_q <= 1'b0;
    end else if (load) begin
      phase <= '0;
    end else if (pulse) begin
      if (cnt_mode) begin
        phase <= phase_nx;
        out_q <= high_nx;
      end else begin
        out_q <= ~out_q;
      end
    end
  end

  // R5: phase stays inside the modulus for a legal M below N
  a_r5_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode && n_dec != '0 && m_val < n_dec) |-> phase < n_dec);

  // R6: outside counter mode each pulse inverts the output
  a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_mode && pulse && !load) |=> out_q != $past(out_q));

  // R7: the switching edge leaves the output level untouched
  a_r7_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> $stable(out_q));
endmodule

// File: rtl/rcg_root.sv
module rcg_root
  import rcg_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_en,
  input  logic        pll_en,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        clk_out
);
  cfg_t          act_cfg;
  logic [MW-1:0] act_m, act_n, act_d;
  logic          apply;
  logic          src_strobe;
  logic          div_pulse;
  logic          cnt_mode;

  rcg_regs #(.MW(MW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .out_level(clk_out),
    .apply(apply), .act_cfg(act_cfg), .act_m(act_m),
    .act_n(act_n), .act_d(act_d)
  );

  assign src_strobe = (act_cfg.src == SRC_PLL) ? pll_en : ref_en;
  assign cnt_mode   = (act_cfg.mode == MODE_COUNTER) && (act_n != '0);

  rcg_halfdiv #(.DW(DIVW)) div_i (
    .clk(clk), .rst_n(rst_n), .strobe(src_strobe), .load(apply),
    .code(act_cfg.div), .pulse(div_pulse)
  );

  rcg_mnd #(.MW(MW)) mnd_i (
    .clk(clk), .rst_n(rst_n), .pulse(div_pulse), .load(apply),
    .cnt_mode(cnt_mode), .m_val(act_m), .n_code(act_n),
    .d_code(act_d), .out_q(clk_out)
  );

  // R2: unused configuration bits never read back
  a_r2_cfg_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_CFG) |-> reg_rdata[31:CFGW] == '0);
endmodule

// File: tb/rcg_root_tb_top.sv
module rcg_root_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0;
  logic        pll_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        clk_out;

  int n_chk = 0;
  int n_bad = 0;
  int ref_cnt = 0;
  bit ref_run = 1'b0;

  always #10 clk = ~clk;

  rcg_root dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .pll_en(pll_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .clk_out(clk_out)
  );

  always @(negedge clk) begin
    if (ref_run) begin
      ref_en  <= (ref_cnt % 3 == 0);
      ref_cnt <= ref_cnt + 1;
    end else begin
      ref_en <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_update(input string tag);
    logic [31:0] v;
    bit done = 1'b0;
    wr_reg(3'd0, 32'd1);
    for (int i = 0; i < 400 && !done; i++) begin
      rd_reg(3'd0, v);
      if (v[0] == 1'b0) done = 1'b1;
    end
    chk(done, tag, 0, 1);
    repeat (40) @(negedge clk);
  endtask

  task automatic count_toggles(input int len, output int tg);
    logic prev;
    tg = 0;
    @(negedge clk);
    prev = clk_out;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (clk_out != prev) tg++;
      prev = clk_out;
    end
  endtask

  task automatic count_high(input int len, output int hi);
    hi = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (clk_out) hi++;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int tg, hi, len;
    int mm [3] = '{3, 1, 5};
    int nn [3] = '{8, 5, 7};
    int dd [3] = '{3, 2, 5};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(clk_out == 1'b0, "R1 clk_out", clk_out, 0);
    for (int a = 0; a < 5; a++) begin
      rd_reg(3'(a), v);
      chk(v == 32'd0, "R1 register reset", v, 0);
    end

    // R2 masking of the upper configuration bits
    wr_reg(3'd1, 32'hFFFF_FFFF);
    rd_reg(3'd1, v);
    chk(v == 32'h0000_3FFF, "R2 cfg mask", v, 32'h3FFF);

    // R4 exhaustive pre-divider sweep on the PLL strobe
    pll_en = 1'b1;
    for (int c = 0; c < 32; c++) begin
      wr_reg(3'd1, 32'h100 | 32'(c));
      do_update("R7 update completes");
      len = (c < 2) ? 8 : 4 * (c + 1);
      count_toggles(len, tg);
      chk(tg == 8, $sformatf("R4 div code %0d", c), tg, 8);
    end

    // R3 source selection
    ref_run = 1'b1;
    wr_reg(3'd1, 32'h000);
    do_update("R7 update completes");
    count_toggles(24, tg);
    chk(tg == 8, "R3 src 0 reference", tg, 8);
    wr_reg(3'd1, 32'h200);
    do_update("R7 update completes");
    count_toggles(24, tg);
    chk(tg == 8, "R3 src 2 reference", tg, 8);
    wr_reg(3'd1, 32'h100);
    do_update("R7 update completes");
    count_toggles(24, tg);
    chk(tg == 24, "R3 src 1 pll", tg, 24);

    // R5 counter mode duty over N pulses
    for (int k = 0; k < 3; k++) begin
      wr_reg(3'd1, 32'h2100);
      wr_reg(3'd2, 32'(mm[k]));
      wr_reg(3'd3, 32'(8'(~(nn[k] - mm[k]))));
      wr_reg(3'd4, 32'(8'(~(2 * dd[k]))));
      do_update("R7 update completes");
      count_high(nn[k] * 4, hi);
      chk(hi == 4 * dd[k], $sformatf("R5 duty M=%0d N=%0d", mm[k], nn[k]), hi, 4 * dd[k]);
    end

    // R6 N-code of zero falls back to toggling
    wr_reg(3'd3, 32'd0);
    do_update("R7 update completes");
    count_toggles(16, tg);
    chk(tg == 16, "R6 zero N toggles", tg, 16);
    wr_reg(3'd1, 32'h1100);
    wr_reg(3'd3, 32'hFA);
    do_update("R7 update completes");
    count_toggles(16, tg);
    chk(tg == 16, "R6 mode 1 toggles", tg, 16);

    // R7 / R8 pending held while output is high
    wr_reg(3'd1, 32'h100);
    wr_reg(3'd2, 32'd3);
    do_update("R7 update completes");
    for (int i = 0; i < 4 && clk_out != 1'b1; i++) @(negedge clk);
    pll_en = 1'b0;
    @(negedge clk);
    chk(clk_out == 1'b1, "R7 output parked high", clk_out, 1);
    wr_reg(3'd0, 32'd1);
    repeat (5) @(negedge clk);
    rd_reg(3'd0, v);
    chk(v[0] == 1'b1, "R7 pending while high", v[0], 1);
    wr_reg(3'd1, 32'h0005);
    wr_reg(3'd2, 32'd7);
    rd_reg(3'd1, v);
    chk(v == 32'h100, "R8 cfg write ignored", v, 32'h100);
    rd_reg(3'd2, v);
    chk(v == 32'd3, "R8 M write ignored", v, 3);
    pll_en = 1'b1;
    do_update("R7 update completes");
    count_toggles(8, tg);
    chk(tg == 8, "R8 active cfg unchanged", tg, 8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule